// File: doc/BRIEF.md
# PDM Microphone Clock and Capture Front End

This block produces the bit clock for up to four pulse-density microphones and turns their data pins into one single-bit stream per channel. The block runs on a single core clock `clk` at twice the reference rate. One reference period is two `clk` cycles. The microphone clock therefore has a period of `2*(prescale+1)` core cycles, which equals the reference rate divided by `prescale+1`. The clock is high and low for equal halves of that period. Each channel picks the microphone clock edge on which it captures: rising or falling. The data pin is oversampled in the core clock domain during the last core cycle before the matching transition, so the design needs no second clock.

Two channels of a pair can share one data pin in stereo mode. This allows two microphones on one wire, each driving on its own clock phase. The polarity bit of each channel still chooses its edge. Typical use is one channel on the rising edge and its partner on the falling edge.

Each captured bit appears on a one-cycle valid strobe with its data. A microphone cannot be stalled, so the stream has no ready input and no back-pressure. A downstream consumer must take each strobe in the cycle it is shown. Configuration pins are plain levels and are sampled continuously.

Top module: `micclk_capture`

## Requirements
- R1: While `run_en` is high, `mic_clk` is low for the first `prescale+1` core cycles after enabling. After that it alternates high and low halves of `prescale+1` core cycles each.
- R2: With `prescale` = 0, `mic_clk` changes level on every core cycle. This is the reference rate.
- R3: A channel whose `edge_inv` bit is 0 pulses `bit_valid` for one cycle, in the cycle where `mic_clk` has just become 1. A channel whose bit is 1 pulses in the cycle where `mic_clk` has just become 0.
- R4: Without stereo, channel c captures pin c. The captured bit is the pin value at the core clock edge that toggles `mic_clk`.
- R5: When `pair_stereo[p]` is 1, channels 2p and 2p+1 both capture pin 2p, each on its own selected edge.
- R6: `ch_count` encodes the number of active channels minus one (0 = one channel … 3 = four channels). A channel with index above `ch_count` never strobes.
- R7: While `run_en` is low, `mic_clk` is held low and no strobes occur. Re-enabling restarts the low half from its beginning.
- R8: After reset, `mic_clk`, `bit_valid` and `bit_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the reference rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Drives the microphone clock and allows capture |
| prescale | input | PRESC_W | Reference divide value minus one |
| ch_count | input | CNT_W | Active channel count minus one |
| edge_inv | input | NUM_CH | Per channel: 0 rising edge, 1 falling edge |
| pair_stereo | input | NUM_CH/2 | Per pair: both channels read the even pin |
| pdm_pin | input | NUM_CH | Microphone data pins |
| mic_clk | output | 1 | Microphone bit clock |
| bit_valid | output | NUM_CH | One-cycle capture strobe per channel |
| bit_data | output | NUM_CH | Captured bit per channel, valid with its strobe |

## Verification
Two events can fall in the same core cycle: a capture edge and the withdrawal of `run_en`. The bench varies how long each run lasts, so the disable lands on different phases of the divider, including the very cycle in which a transition and capture would have occurred. In that cycle the expected model requires no strobe and a low clock. A second case is a stereo pair at `prescale` 0, where rising and falling captures come in consecutive cycles from one pin. Each captured bit is judged against the pin value the bench drove at that exact edge.

// File: rtl/pdm_fe_pkg.sv
package pdm_fe_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;

  // Pin index a channel reads: even pin of its pair in stereo, own pin otherwise.
  function automatic int unsigned src_index(input int unsigned ch, input logic stereo);
    return stereo ? (ch & ~32'd1) : ch;
  endfunction
endpackage

// File: rtl/pdm_clk_div.sv
module pdm_clk_div #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic [PRESC_W-1:0] prescale,
  output logic               mic_clk,
  output logic               rise_next,
  output logic               fall_next
);
  logic [PRESC_W-1:0] cnt;
  logic               phase;
  logic               half_done;

  assign half_done = (cnt >= prescale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!run_en) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (half_done) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign mic_clk   = phase;
  assign rise_next = run_en & ~phase & half_done;
  assign fall_next = run_en &  phase & half_done;
endmodule

// File: rtl/pdm_pin_route.sv
module pdm_pin_route
  import pdm_fe_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH/2-1:0] pair_stereo,
  input  logic [NUM_CH-1:0]   pdm_pin,
  output logic [NUM_CH-1:0]   ch_src
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_route
    localparam int unsigned MONO_IDX   = c;
    localparam int unsigned STEREO_IDX = c & ~1;
    assign ch_src[c] = pair_stereo[c/2] ? pdm_pin[STEREO_IDX] : pdm_pin[MONO_IDX];
  end
endmodule

// File: rtl/pdm_bit_sampler.sv
module pdm_bit_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic src_bit,
  output logic bit_valid,
  output logic bit_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_valid <= 1'b0;
      bit_data  <= 1'b0;
    end else begin
      bit_valid <= take;
      if (take) bit_data <= src_bit;
    end
  end
endmodule

// File: rtl/micclk_capture.sv
module micclk_capture
  import pdm_fe_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int PRESC_W = 8,
  parameter int CNT_W   = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic [PRESC_W-1:0]  prescale,
  input  logic [CNT_W-1:0]    ch_count,
  input  logic [NUM_CH-1:0]   edge_inv,
  input  logic [NUM_CH/2-1:0] pair_stereo,
  input  logic [NUM_CH-1:0]   pdm_pin,
  output logic                mic_clk,
  output logic [NUM_CH-1:0]   bit_valid,
  output logic [NUM_CH-1:0]   bit_data
);
  logic              rise_next;
  logic              fall_next;
  logic [NUM_CH-1:0] ch_src;
  logic [NUM_CH-1:0] take;

  pdm_clk_div #(.PRESC_W(PRESC_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .prescale  (prescale),
    .mic_clk   (mic_clk),
    .rise_next (rise_next),
    .fall_next (fall_next)
  );

  pdm_pin_route #(.NUM_CH(NUM_CH)) u_route (
    .pair_stereo (pair_stereo),
    .pdm_pin     (pdm_pin),
    .ch_src      (ch_src)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic      active;
    edge_sel_e sel;
    assign active  = (c <= int'(ch_count));
    assign sel     = edge_sel_e'(edge_inv[c]);
    assign take[c] = active & ((sel == EDGE_FALL) ? fall_next : rise_next);

    pdm_bit_sampler u_smp (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take[c]),
      .src_bit   (ch_src[c]),
      .bit_valid (bit_valid[c]),
      .bit_data  (bit_data[c])
    );
  end
endmodule

// File: rtl/micclk_capture_chk.sv
module micclk_capture_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic [CNT_W-1:0]  ch_count,
  input logic [NUM_CH-1:0] edge_inv,
  input logic              mic_clk,
  input logic [NUM_CH-1:0] bit_valid
);
  logic [NUM_CH-1:0] inv_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W:0]    shamt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_q <= '0;
      cnt_q <= '0;
    end else begin
      inv_q <= edge_inv;
      cnt_q <= ch_count;
    end
  end

  assign shamt = {1'b0, cnt_q} + 1'b1;

  // R7: a disabled block is silent one cycle later
  assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!mic_clk && (bit_valid == '0)));

  // R3: rising-edge channels strobe only as the clock rises
  assert_rise_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(bit_valid & ~inv_q)) |-> $rose(mic_clk));

  // R3: falling-edge channels strobe only as the clock falls
  assert_fall_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(bit_valid & inv_q)) |-> $fell(mic_clk));

  // R6: channels above the active count stay silent
  assert_inactive_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid >> shamt) == '0);
endmodule

bind micclk_capture micclk_capture_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_en    (run_en),
  .ch_count  (ch_count),
  .edge_inv  (edge_inv),
  .mic_clk   (mic_clk),
  .bit_valid (bit_valid)
);

// File: tb/sim_micclk_capture.sv
module sim_micclk_capture;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 4;
  localparam int PW         = 8;
  localparam int CW         = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              run_en = 1'b0;
  logic [PW-1:0]     prescale = '0;
  logic [CW-1:0]     ch_count = '0;
  logic [NUM_CH-1:0] edge_inv = '0;
  logic [NUM_CH/2-1:0] pair_stereo = '0;
  logic [NUM_CH-1:0] pdm_pin = '0;
  logic              mic_clk;
  logic [NUM_CH-1:0] bit_valid;
  logic [NUM_CH-1:0] bit_data;

  int checks = 0;
  int errors = 0;
  int t = 0;
  logic [NUM_CH-1:0] pin_edge;

  always #(CLK_PERIOD/2) clk = ~clk;

  micclk_capture #(.NUM_CH(NUM_CH), .PRESC_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .prescale(prescale),
    .ch_count(ch_count), .edge_inv(edge_inv), .pair_stereo(pair_stereo),
    .pdm_pin(pdm_pin), .mic_clk(mic_clk), .bit_valid(bit_valid), .bit_data(bit_data)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // One core cycle: track the edge count and pin values, then judge outputs mid-cycle.
  task automatic step();
    int  h, q, src;
    bit  at_edge, rise, fall, active, want, exp_clk;
    string tag;
    @(posedge clk);
    if (run_en && rst_n) t++; else t = 0;
    pin_edge = pdm_pin;
    @(negedge clk);
    h       = int'(prescale) + 1;
    q       = t / h;
    at_edge = (t > 0) && (t % h == 0);
    exp_clk = (q % 2) == 1;
    rise    = at_edge && exp_clk;
    fall    = at_edge && !exp_clk;
    tag     = !run_en ? "R7" : (prescale == 0 ? "R2" : "R1");
    check(mic_clk === exp_clk, tag, "mic_clk", int'(mic_clk), int'(exp_clk));
    for (int c = 0; c < NUM_CH; c++) begin
      active = (c <= int'(ch_count));
      src    = pair_stereo[c/2] ? (c & ~1) : c;
      want   = active && (edge_inv[c] ? fall : rise);
      tag    = !run_en ? "R7" : (!active ? "R6" : "R3");
      check(bit_valid[c] === want, tag, $sformatf("bit_valid[%0d]", c),
            int'(bit_valid[c]), int'(want));
      if (want) begin
        tag = pair_stereo[c/2] ? "R5" : "R4";
        check(bit_data[c] === pin_edge[src], tag, $sformatf("bit_data[%0d]", c),
              int'(bit_data[c]), int'(pin_edge[src]));
      end
    end
    pdm_pin = NUM_CH'($urandom);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset values
    check(mic_clk === 1'b0, "R8", "mic_clk", int'(mic_clk), 0);
    check(bit_valid === '0, "R8", "bit_valid", int'(bit_valid), 0);
    check(bit_data === '0, "R8", "bit_data", int'(bit_data), 0);
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 4; n++) begin
        for (int s = 0; s < 4; s++) begin
          for (int i = 0; i < 16; i++) begin
            int len;
            run_en      = 1'b0;
            prescale    = PW'(p);
            ch_count    = CW'(n);
            pair_stereo = 2'(s);
            edge_inv    = NUM_CH'(i);
            step();
            step();
            run_en = 1'b1;
            len = 6 * (p + 1) + (i % 3);
            for (int k = 0; k < len; k++) step();
          end
        end
      end
    end
    run_en = 1'b0;
    step();
    finish_run();
  end
endmodule